// File: doc/BRIEF.md
# Trap Routing and Vector Generator

This block takes a trap request and decides which handling path it follows: the recovery path, the hyper-level path, the privileged path, or an error stop when the trap stack is full. For the chosen path it computes the handler fetch address and the address after it. It also reports the trap type that the handler will see. Saving the machine state is done elsewhere. This block only chooses the path and forms the vector.

The caller presents the current trap level, the recovery and hyper-level status bits, the privileged status bit, the trap type, the privilege level the trap asks for, and the two table base addresses, and pulses `req_i` for one cycle. One cycle later the result is on the outputs with `valid_o` high for a single cycle. The result stays on the outputs until the next request.

Top module: `trap_router`

## Requirements
- R1: A cycle with `req_i` high makes `valid_o` high in the next cycle only. `mode_o`, `tt_o`, `pc_o` and `npc_o` change only in the cycle after a request and otherwise hold their values. After reset all outputs are zero.
- R2: The current level is hyper (2) when `hpriv_i` is set, otherwise privileged (1) when `priv_i` is set, otherwise user (0). The effective target level is the larger of the current level and `tgt_lvl_i` (0 user, 1 privileged, 2 or 3 hyper).
- R3: When `red_i` is set or `tl_i` equals MAX_TL-1, `mode_o` is 2 (recovery), `tt_o` equals `tt_i`, and `pc_o` is 0xFFF00000A0, which is the recovery base ORed with the low byte of the fixed type 5 shifted left by 5.
- R4: When R3 does not apply and `tl_i` equals MAX_TL, `mode_o` is 3 (error), `tt_o` equals `tt_i`, and `pc_o` and `npc_o` are 0.
- R5: When neither R3 nor R4 applies, `tl_i` is above MAX_PTL and the effective level is privileged, `mode_o` is 1 (hyper) and `tt_o` is 2 (guest watchdog).
- R6: Otherwise, when the effective level is hyper, or it is privileged and `tt_i` is 384 or more, `mode_o` is 1 and `tt_o` equals `tt_i`. All remaining requests give `mode_o` 0 (privileged) with `tt_o` equal to `tt_i`.
- R7: In hyper mode `pc_o` is `hbase_i` with bits 13:0 cleared, ORed with `tt_o` shifted left by 5 into bits 13:5.
- R8: In privileged mode `pc_o` is `pbase_i` with bits 14:0 cleared, with bit 14 set when `tl_i`+1 is greater than 1, and with `tt_i` shifted left by 5 into bits 13:5.
- R9: Except in error mode, `npc_o` equals `pc_o` + 4.
- R10: The checks are applied in the priority order R3, R4, R5, R6. For example, `red_i` set together with `tl_i` equal to MAX_TL gives recovery mode, and a hyper target at a trap level above MAX_PTL gives hyper mode with its own type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Trap request strobe |
| tl_i | input | TL_W (3) | Current trap level |
| red_i | input | 1 | Recovery status bit |
| hpriv_i | input | 1 | Hyper-level status bit |
| priv_i | input | 1 | Privileged status bit |
| tt_i | input | TT_W (9) | Trap type |
| tgt_lvl_i | input | 2 | Privilege level requested by the trap |
| hbase_i | input | ADDR_W (64) | Hyper table base |
| pbase_i | input | ADDR_W (64) | Privileged table base |
| valid_o | output | 1 | Result valid for one cycle |
| mode_o | output | 2 | 0 privileged, 1 hyper, 2 recovery, 3 error |
| tt_o | output | TT_W (9) | Effective trap type |
| pc_o | output | ADDR_W (64) | Handler address |
| npc_o | output | ADDR_W (64) | Handler next address |

## Verification
The assertions assume that `tl_i` never exceeds MAX_TL. A level above MAX_TL would skip both the recovery check and the error check, and the routing properties do not cover that case. The assertions also assume that the request inputs are steady during the cycle of the strobe. The bench drives only trap levels from 0 to MAX_TL, changes inputs only at the falling edge, and checks the routing at each level boundary: MAX_PTL, MAX_PTL+1, MAX_TL-1 and MAX_TL.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;
  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_PRIV  = 2'd1,
    LVL_HYPER = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    MODE_PRIV  = 2'd0,
    MODE_HYPER = 2'd1,
    MODE_RED   = 2'd2,
    MODE_ERROR = 2'd3
  } mode_e;
endpackage

// File: rtl/trap_classify.sv
module trap_classify import trap_route_pkg::*; #(
  parameter int MAX_TL     = 6,
  parameter int MAX_PTL    = 2,
  parameter int TT_W       = 9,
  parameter int HYP_TT_MIN = 384,
  parameter int WDOG_TT    = 2,
  localparam int TL_W      = $clog2(MAX_TL + 1)
) (
  input  logic [TL_W-1:0] tl_i,
  input  logic            red_i,
  input  logic            hpriv_i,
  input  logic            priv_i,
  input  logic [TT_W-1:0] tt_i,
  input  logic [1:0]      tgt_lvl_i,
  output mode_e           mode_o,
  output logic [TT_W-1:0] tt_o,
  output logic            tl_gt1_o
);
  logic [1:0] cur_lvl, eff_lvl;
  logic       eff_hyper, eff_priv;

  always_comb begin
    if (hpriv_i)     cur_lvl = LVL_HYPER;
    else if (priv_i) cur_lvl = LVL_PRIV;
    else             cur_lvl = LVL_USER;
  end

  assign eff_lvl   = (cur_lvl > tgt_lvl_i) ? cur_lvl : tgt_lvl_i;
  assign eff_hyper = eff_lvl >= 2'(LVL_HYPER);
  assign eff_priv  = eff_lvl == 2'(LVL_PRIV);
  // new level = tl+1 > 1  <=>  tl != 0
  assign tl_gt1_o  = tl_i != '0;

  always_comb begin
    tt_o = tt_i;
    if (red_i || int'(tl_i) == MAX_TL - 1) begin
      mode_o = MODE_RED;
    end else if (int'(tl_i) == MAX_TL) begin
      mode_o = MODE_ERROR;
    end else if (int'(tl_i) > MAX_PTL && eff_priv) begin
      mode_o = MODE_HYPER;
      tt_o   = TT_W'(WDOG_TT);
    end else if (eff_hyper || (eff_priv && int'(tt_i) >= HYP_TT_MIN)) begin
      mode_o = MODE_HYPER;
    end else begin
      mode_o = MODE_PRIV;
    end
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector import trap_route_pkg::*; #(
  parameter int          TT_W     = 9,
  parameter int          ADDR_W   = 64,
  parameter int          INSN_B   = 4,
  parameter logic [63:0] RED_BASE = 64'h0000_00FF_F000_0000,
  parameter int          RED_TT   = 5,
  localparam int         SLOT_SH  = 5,
  localparam int         HYP_LSB  = TT_W + SLOT_SH,
  localparam int         PRV_LSB  = HYP_LSB + 1
) (
  input  mode_e             mode_i,
  input  logic [TT_W-1:0]   tt_i,
  input  logic              tl_gt1_i,
  input  logic [ADDR_W-1:0] hbase_i,
  input  logic [ADDR_W-1:0] pbase_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o
);
  localparam logic [ADDR_W-1:0] RED_PC =
    ADDR_W'(RED_BASE) | ADDR_W'((RED_TT << SLOT_SH) & 8'hFF);

  logic [ADDR_W-1:0] slot, hyp_pc, prv_pc;

  assign slot   = ADDR_W'({tt_i, {SLOT_SH{1'b0}}});
  assign hyp_pc = {hbase_i[ADDR_W-1:HYP_LSB], {HYP_LSB{1'b0}}} | slot;
  assign prv_pc = {pbase_i[ADDR_W-1:PRV_LSB], tl_gt1_i, {HYP_LSB{1'b0}}} | slot;

  always_comb begin
    unique case (mode_i)
      MODE_RED:   pc_o = RED_PC;
      MODE_HYPER: pc_o = hyp_pc;
      MODE_PRIV:  pc_o = prv_pc;
      default:    pc_o = '0;
    endcase
    npc_o = (mode_i == MODE_ERROR) ? '0 : pc_o + ADDR_W'(INSN_B);
  end
endmodule

// File: rtl/trap_router.sv
module trap_router import trap_route_pkg::*; #(
  parameter int  MAX_TL  = 6,
  parameter int  MAX_PTL = 2,
  parameter int  TT_W    = 9,
  parameter int  ADDR_W  = 64,
  localparam int TL_W    = $clog2(MAX_TL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [TL_W-1:0]   tl_i,
  input  logic              red_i,
  input  logic              hpriv_i,
  input  logic              priv_i,
  input  logic [TT_W-1:0]   tt_i,
  input  logic [1:0]        tgt_lvl_i,
  input  logic [ADDR_W-1:0] hbase_i,
  input  logic [ADDR_W-1:0] pbase_i,
  output logic              valid_o,
  output logic [1:0]        mode_o,
  output logic [TT_W-1:0]   tt_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o
);
  mode_e             mode_d;
  logic [TT_W-1:0]   tt_d;
  logic              tl_gt1;
  logic [ADDR_W-1:0] pc_d, npc_d;

  trap_classify #(
    .MAX_TL (MAX_TL),
    .MAX_PTL(MAX_PTL),
    .TT_W   (TT_W)
  ) i_classify (
    .tl_i     (tl_i),
    .red_i    (red_i),
    .hpriv_i  (hpriv_i),
    .priv_i   (priv_i),
    .tt_i     (tt_i),
    .tgt_lvl_i(tgt_lvl_i),
    .mode_o   (mode_d),
    .tt_o     (tt_d),
    .tl_gt1_o (tl_gt1)
  );

  trap_vector #(
    .TT_W  (TT_W),
    .ADDR_W(ADDR_W)
  ) i_vector (
    .mode_i  (mode_d),
    .tt_i    (tt_d),
    .tl_gt1_i(tl_gt1),
    .hbase_i (hbase_i),
    .pbase_i (pbase_i),
    .pc_o    (pc_d),
    .npc_o   (npc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mode_o  <= '0;
      tt_o    <= '0;
      pc_o    <= '0;
      npc_o   <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        mode_o <= mode_d;
        tt_o   <= tt_d;
        pc_o   <= pc_d;
        npc_o  <= npc_d;
      end
    end
  end
endmodule

// File: rtl/trap_router_chk.sv
module trap_router_chk #(
  parameter int  MAX_TL  = 6,
  parameter int  MAX_PTL = 2,
  parameter int  TT_W    = 9,
  parameter int  ADDR_W  = 64,
  localparam int TL_W    = $clog2(MAX_TL + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [TL_W-1:0]   tl_i,
  input logic              red_i,
  input logic              hpriv_i,
  input logic              priv_i,
  input logic [TT_W-1:0]   tt_i,
  input logic [1:0]        tgt_lvl_i,
  input logic [ADDR_W-1:0] hbase_i,
  input logic [ADDR_W-1:0] pbase_i,
  input logic              valid_o,
  input logic [1:0]        mode_o,
  input logic [TT_W-1:0]   tt_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] npc_o
);
  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(pc_o) && $stable(mode_o) && $stable(tt_o)); // R1
  AST_HYPER_CURRENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !red_i && int'(tl_i) < MAX_TL - 1 && hpriv_i |=> mode_o == 2'd1); // R2
  AST_RED_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && red_i |=> mode_o == 2'd2 && pc_o == ADDR_W'(64'hFF_F000_00A0)); // R3
  AST_ERROR_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !red_i && int'(tl_i) == MAX_TL |=> mode_o == 2'd3 && pc_o == '0); // R4
  AST_GUEST_WDOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !red_i && !hpriv_i && tgt_lvl_i == 2'd1 && int'(tl_i) > MAX_PTL
      && int'(tl_i) < MAX_TL - 1 |=> mode_o == 2'd1 && tt_o == TT_W'(2)); // R5
  AST_NPC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && mode_o != 2'd3 |-> npc_o == pc_o + ADDR_W'(4)); // R9
  AST_SLOT_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && mode_o == 2'd1 |-> pc_o[4:0] == '0 && pc_o[13:5] == tt_o); // R7
endmodule

bind trap_router trap_router_chk #(
  .MAX_TL (MAX_TL),
  .MAX_PTL(MAX_PTL),
  .TT_W   (TT_W),
  .ADDR_W (ADDR_W)
) i_chk (.*);

// File: tb/test_trap_router.sv
`timescale 1ns/1ps
module test_trap_router;
  localparam int MAX_TL = 6, MAX_PTL = 2, TT_W = 9, ADDR_W = 64;
  localparam int TL_W = $clog2(MAX_TL + 1);
  localparam logic [63:0] HB = 64'h0000_00AB_CDEF_7FFF;
  localparam logic [63:0] PB = 64'h0000_1234_5678_ABCD;

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0;
  logic [TL_W-1:0] tl_i = '0;
  logic red_i = 0, hpriv_i = 0, priv_i = 0;
  logic [TT_W-1:0] tt_i = '0;
  logic [1:0] tgt_lvl_i = '0;
  logic [ADDR_W-1:0] hbase_i = HB, pbase_i = PB;
  logic valid_o;
  logic [1:0] mode_o;
  logic [TT_W-1:0] tt_o;
  logic [ADDR_W-1:0] pc_o, npc_o;

  int checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  trap_router #(.MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .TT_W(TT_W), .ADDR_W(ADDR_W))
    i_trap_router (.*);

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // independent expectation: mode, tt, pc
  task automatic issue(string rq, int tl, bit red, bit hp, bit pv, int tt, int tgt,
                       int emode, int ett);
    logic [63:0] epc;
    @(negedge clk_i);
    tl_i = TL_W'(tl); red_i = red; hpriv_i = hp; priv_i = pv;
    tt_i = TT_W'(tt); tgt_lvl_i = 2'(tgt); req_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    case (emode)
      2: epc = 64'hFF_F000_00A0;
      1: epc = (HB & ~64'h3FFF) | ((64'(ett) << 5) & 64'h3FFF);
      0: epc = (PB & ~64'h7FFF) | ((tl + 1 > 1) ? 64'h4000 : 64'h0)
               | ((64'(ett) << 5) & 64'h3FFF);
      default: epc = 64'h0;
    endcase
    chk(rq, "valid", 64'(valid_o), 64'd1);
    chk(rq, "mode", 64'(mode_o), 64'(emode));
    chk(rq, "tt", 64'(tt_o), 64'(ett));
    chk(rq, "pc", pc_o, epc);
    chk("R9", "npc", npc_o, emode == 3 ? 64'h0 : epc + 64'd4);
  endtask

  task automatic t_reset;
    chk("R1", "reset valid", 64'(valid_o), 64'd0);
    chk("R1", "reset pc", pc_o, 64'd0);
    chk("R1", "reset mode", 64'(mode_o), 64'd0);
  endtask

  task automatic t_priv;
    issue("R8", 0, 0, 0, 0, 'h24, 1, 0, 'h24);   // tl0: no bit 14
    issue("R8", 1, 0, 0, 1, 'h80, 1, 0, 'h80);   // tl1: bit 14
    issue("R8", 2, 0, 0, 0, 'h17F, 1, 0, 'h17F); // MAX_PTL still privileged
  endtask

  task automatic t_levels;
    issue("R2", 0, 0, 0, 0, 'h30, 0, 0, 'h30);   // user->user: privileged path
    issue("R2", 0, 0, 1, 0, 'h30, 1, 1, 'h30);   // current hyper raises level
    issue("R2", 1, 0, 0, 1, 'h30, 0, 0, 'h30);   // current priv kept
  endtask

  task automatic t_hyper;
    issue("R6", 0, 0, 0, 0, 'h180, 1, 1, 'h180); // 384 goes hyper
    issue("R7", 1, 0, 0, 0, 'h1FF, 2, 1, 'h1FF);
    issue("R7", 3, 0, 0, 0, 'h10, 3, 1, 'h10);   // R10: hyper over wdog
  endtask

  task automatic t_wdog;
    issue("R5", 3, 0, 0, 0, 'h41, 1, 1, 2);
    issue("R5", 4, 0, 0, 1, 'h1A0, 0, 1, 2);
  endtask

  task automatic t_red_err;
    issue("R3", 0, 1, 1, 0, 'h33, 2, 2, 'h33);
    issue("R3", 5, 0, 0, 0, 'h24, 1, 2, 'h24);
    issue("R4", 6, 0, 0, 1, 'h24, 1, 3, 'h24);
    issue("R10", 6, 1, 0, 0, 'h24, 1, 2, 'h24);
  endtask

  task automatic t_hold;
    logic [63:0] pc_prev = pc_o;
    @(negedge clk_i);
    tl_i = '0; red_i = 0; tt_i = 'h55; tgt_lvl_i = 2; hbase_i = '1; pbase_i = '1;
    repeat (3) @(negedge clk_i);
    chk("R1", "idle valid", 64'(valid_o), 64'd0);
    chk("R1", "idle pc held", pc_o, pc_prev);
    chk("R1", "idle mode held", 64'(mode_o), 64'd2);
    hbase_i = HB; pbase_i = PB;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_priv();
    t_levels();
    t_hyper();
    t_wdog();
    t_red_err();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule